// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous request port and an external asynchronous static RAM that is 16 bits wide with 21 address bits. It accepts one word-sized read or write at a time through a valid/ready handshake, with a two-bit byte mask selecting which halves of the word take part. Each accepted request becomes a strobe sequence on the RAM pins. The length of every phase is a whole number of clock cycles, found by dividing the RAM's nanosecond limits by the clock period and rounding up.

Reads keep the chip selected, with the read-enable strobe and the chosen byte strobes held active, for long enough that the data is valid before it is captured. The captured word comes back with a one-cycle valid flag. Writes hold the write strobe low for the full pulse and drive the data bus the whole time. After the strobe rises, the address and data stay in place for a short recovery. The data bus direction is owned by the controller. After a read, it waits out the RAM's output turn-off delay before it drives the bus for a write.

Every strobe is a register output. The address and byte strobes change only while the chip is deselected.

Top module: `asram_seq`

## Requirements
- R1: After reset, `ram_sel_n`=1, `ram_sel`=0, `ram_rd_en_n`=1, `ram_wr_en_n`=1, `ram_hi_n`=1, `ram_lo_n`=1, `ram_dat_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From that edge until the controller is idle again, `req_ready` is 0, and it is always 0 while the chip is selected.
- R3: A read holds the chip selected and `ram_rd_en_n` low for N_RD = ceil(max(45, 45, 22, 45 ns) / period) cycles (12 at a 4 ns clock). The data pins are captured on the edge that ends this window. `rsp_valid` is then 1 for exactly the one cycle that follows the window.
- R4: Mask bit 0 selects bits 7:0 and drives `ram_lo_n` low. Mask bit 1 selects bits 15:8 and drives `ram_hi_n` low. In `rsp_rdata`, any lane that is not selected reads as zero. A mask of 00 returns 0.
- R5: A write holds `ram_wr_en_n` low, with the chip selected and the selected byte strobes low, for N_WR = ceil(max(35, 35, 25 ns) / period) cycles (9 at 4 ns). Throughout this pulse, `ram_dat_oe` is 1 and `ram_dat_o` holds the request data unchanged.
- R6: After `ram_wr_en_n` rises, the address and data stay driven so that `ram_dat_oe` is 1 for N_WC = max(ceil(45 ns / period), N_WR+1) cycles in total (12 at 4 ns).
- R7: `ram_rd_en_n` is low only during reads. It is never low while `ram_dat_oe` is 1 or `ram_wr_en_n` is low.
- R8: `ram_dat_oe` rises no sooner than N_HZ = ceil(18 ns / period) cycles (5 at 4 ns) after `ram_rd_en_n` last rose.
- R9: While the chip stays selected from one cycle to the next, `ram_addr`, `ram_hi_n` and `ram_lo_n` do not change.
- R10: A write with mask 00 leaves both byte strobes high, so the stored word is unchanged when it is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask: bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | 21 | RAM address |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel | output | 1 | Active-high chip select |
| ram_rd_en_n | output | 1 | Active-low output enable of the RAM |
| ram_wr_en_n | output | 1 | Active-low write strobe |
| ram_hi_n | output | 1 | Active-low strobe for bits 15:8 |
| ram_lo_n | output | 1 | Active-low strobe for bits 7:0 |
| ram_dat_o | output | 16 | Data toward the RAM |
| ram_dat_oe | output | 1 | Drive enable for ram_dat_o |
| ram_dat_i | input | 16 | Data from the RAM pins |

## Verification
The bench's RAM model returns the complement of the stored word until 45 ns after the read strobes become active. A controller that captures even one cycle early therefore returns corrupted read data. A read followed at once by a write exercises the bus turnaround: a design that drives the bus too early is caught by the cycle count between the read-enable strobe rising and the drive enable rising. Single-lane writes and reads, and an all-zero mask, would show up as lane mixing or stray writes. Each write pulse is measured for width and for data stability, and the drive window is measured for length, so a shortened pulse or an early release of the bus would be reported.

// File: rtl/asram_pkg.sv
// Shared types and helpers for the static RAM cycle controller.
// Assumes a 16-bit RAM split into two byte lanes.
package asram_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WREC
    } seq_state_e;

    // Whole clock cycles covering a nanosecond limit (rounded up).
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_delay_cnt.sv
// Loadable down-counter used to time a phase.
// done is high once the count has reached zero; it stays there until reloaded.
module asram_delay_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Load a new count or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_seq_fsm.sv
// Sequencer for the RAM access phases. It picks the next phase, loads the phase
// and turnaround counters, and registers the strobes from the next state so
// that every pin changes cleanly on a clock edge.
// Assumes the phase lengths passed in are all at least 1.
module asram_seq_fsm
    import asram_pkg::*;
#(
    parameter int unsigned CW    = 4,
    parameter int unsigned N_RD  = 12,
    parameter int unsigned N_WR  = 9,
    parameter int unsigned N_REC = 3,
    parameter int unsigned N_HZ  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          ph_done,
    input  logic          hz_done,
    output logic          ph_load,
    output logic [CW-1:0] ph_val,
    output logic          hz_load,
    output logic [CW-1:0] hz_val,
    output logic          acc,
    output logic          sel_nxt,
    output logic          cap_en,
    output logic          ready_q,
    output logic          sel_q,
    output logic          rd_q,
    output logic          wr_q,
    output logic          drv_q
);

    localparam logic [CW-1:0] L_RD  = CW'(N_RD - 1);
    localparam logic [CW-1:0] L_WR  = CW'(N_WR - 1);
    localparam logic [CW-1:0] L_REC = CW'(N_REC - 1);
    localparam logic [CW-1:0] L_HZ  = CW'(N_HZ - 1);

    seq_state_e state_q, nxt;

    // Next-phase choice and counter loads.
    always_comb begin
        nxt     = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        hz_load = 1'b0;
        acc     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    acc = 1'b1;
                    if (!req_write) begin
                        nxt     = ST_READ;
                        ph_load = 1'b1;
                        ph_val  = L_RD;
                    end else if (!hz_done) begin
                        nxt = ST_TURN;
                    end else begin
                        nxt     = ST_WPULSE;
                        ph_load = 1'b1;
                        ph_val  = L_WR;
                    end
                end
            end
            ST_READ: begin
                if (ph_done) begin
                    nxt     = ST_IDLE;
                    hz_load = 1'b1;
                end
            end
            ST_TURN: begin
                if (hz_done) begin
                    nxt     = ST_WPULSE;
                    ph_load = 1'b1;
                    ph_val  = L_WR;
                end
            end
            ST_WPULSE: begin
                if (ph_done) begin
                    nxt     = ST_WREC;
                    ph_load = 1'b1;
                    ph_val  = L_REC;
                end
            end
            ST_WREC: begin
                if (ph_done)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign hz_val  = L_HZ;
    assign sel_nxt = (nxt == ST_READ) || (nxt == ST_WPULSE);
    assign cap_en  = (state_q == ST_READ) && ph_done;

    // Phase register and registered strobes derived from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b1;
            sel_q   <= 1'b0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            drv_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            ready_q <= (nxt == ST_IDLE);
            sel_q   <= sel_nxt;
            rd_q    <= (nxt == ST_READ);
            wr_q    <= (nxt == ST_WPULSE);
            drv_q   <= (nxt == ST_WPULSE) || (nxt == ST_WREC);
        end
    end

endmodule

// File: rtl/asram_seq_dpath.sv
// Data path: holds the address, write data and byte mask of the current
// request, registers the byte strobes and captures read data per lane.
// Assumes acc only pulses while the chip is deselected.
module asram_seq_dpath
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              sel_nxt,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ram_dat_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  lane_n,
    output logic              rsp_valid_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] lane_act_q;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (acc) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_be;
        end
    end

    // Byte strobes are active only in the strobe phases, per the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lane_act_q <= '0;
        else if (sel_nxt)
            lane_act_q <= acc ? req_be : mask_q;
        else
            lane_act_q <= '0;
    end

    assign lane_n = ~lane_act_q;

    // Response valid follows the capture edge by one register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_valid_q <= 1'b0;
        else
            rsp_valid_q <= cap_en;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture one byte lane, zero when the lane was not selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata_q[g*8 +: 8] <= 8'h00;
            else if (cap_en)
                rdata_q[g*8 +: 8] <= mask_q[g] ? ram_dat_i[g*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/asram_seq.sv
// Top of the static RAM cycle controller. It converts nanosecond limits into
// cycle counts, and wires the sequencer, the two delay counters and the data
// path together.
// Assumes a 16-bit RAM with two byte lanes and a free-running clock of
// CLK_PERIOD_NS.
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 21,
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned T_RC_NS       = 45,
    parameter int unsigned T_AA_NS       = 45,
    parameter int unsigned T_DOE_NS      = 22,
    parameter int unsigned T_DBE_NS      = 45,
    parameter int unsigned T_WC_NS       = 45,
    parameter int unsigned T_PWE_NS      = 35,
    parameter int unsigned T_WEND_NS     = 35,
    parameter int unsigned T_SD_NS       = 25,
    parameter int unsigned T_HZ_NS       = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel,
    output logic              ram_rd_en_n,
    output logic              ram_wr_en_n,
    output logic              ram_hi_n,
    output logic              ram_lo_n,
    output logic [15:0]       ram_dat_o,
    output logic              ram_dat_oe,
    input  logic [15:0]       ram_dat_i
);

    localparam int unsigned P     = CLK_PERIOD_NS;
    localparam int unsigned N_RD  = max2(max2(ns_to_cyc(T_RC_NS, P), ns_to_cyc(T_AA_NS, P)),
                                         max2(ns_to_cyc(T_DOE_NS, P), ns_to_cyc(T_DBE_NS, P)));
    localparam int unsigned N_WR  = max2(max2(ns_to_cyc(T_PWE_NS, P), ns_to_cyc(T_WEND_NS, P)),
                                         ns_to_cyc(T_SD_NS, P));
    localparam int unsigned N_WC  = max2(ns_to_cyc(T_WC_NS, P), N_WR + 1);
    localparam int unsigned N_REC = N_WC - N_WR;
    localparam int unsigned N_HZ  = max2(ns_to_cyc(T_HZ_NS, P), 1);
    localparam int unsigned N_MAX = max2(max2(N_RD, N_WR), max2(N_REC, N_HZ));
    localparam int unsigned CW    = $clog2(N_MAX + 1);

    logic          ph_load, hz_load, ph_done, hz_done;
    logic [CW-1:0] ph_val, hz_val;
    logic          acc, sel_nxt, cap_en;
    logic          sel_q, rd_q, wr_q, drv_q;
    logic [1:0]    lane_n;

    asram_seq_fsm #(
        .CW(CW), .N_RD(N_RD), .N_WR(N_WR), .N_REC(N_REC), .N_HZ(N_HZ)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .ph_done(ph_done), .hz_done(hz_done),
        .ph_load(ph_load), .ph_val(ph_val),
        .hz_load(hz_load), .hz_val(hz_val),
        .acc(acc), .sel_nxt(sel_nxt), .cap_en(cap_en),
        .ready_q(req_ready), .sel_q(sel_q), .rd_q(rd_q), .wr_q(wr_q), .drv_q(drv_q)
    );

    asram_delay_cnt #(.CW(CW)) u_phase_cnt (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .done(ph_done)
    );

    asram_delay_cnt #(.CW(CW)) u_turn_cnt (
        .clk(clk), .rst_n(rst_n), .load(hz_load), .load_val(hz_val), .done(hz_done)
    );

    asram_seq_dpath #(.ADDR_W(ADDR_W)) u_dpath (
        .clk(clk), .rst_n(rst_n), .acc(acc),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .sel_nxt(sel_nxt), .cap_en(cap_en), .ram_dat_i(ram_dat_i),
        .addr_q(ram_addr), .wdata_q(ram_dat_o), .lane_n(lane_n),
        .rsp_valid_q(rsp_valid), .rdata_q(rsp_rdata)
    );

    assign ram_sel_n   = ~sel_q;
    assign ram_sel     = sel_q;
    assign ram_rd_en_n = ~rd_q;
    assign ram_wr_en_n = ~wr_q;
    assign ram_dat_oe  = drv_q;
    assign ram_hi_n    = lane_n[1];
    assign ram_lo_n    = lane_n[0];

endmodule

// File: rtl/asram_seq_chk.sv
// Property checker for the static RAM controller, bound onto the top module.
// It watches only the top-level ports; cycle windows are measured with
// small saturating counters.
module asram_seq_chk #(
    parameter int unsigned N_WR   = 9,
    parameter int unsigned N_HZ   = 5,
    parameter int unsigned ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_sel_n,
    input logic              ram_sel,
    input logic              ram_rd_en_n,
    input logic              ram_wr_en_n,
    input logic              ram_hi_n,
    input logic              ram_lo_n,
    input logic              ram_dat_oe
);

    logic [7:0] wlow_cnt;
    logic [7:0] rdoff_cnt;

    // Cycles the write strobe has been low so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wlow_cnt <= 8'd0;
        else if (!ram_wr_en_n) begin
            if (wlow_cnt != 8'hFF)
                wlow_cnt <= wlow_cnt + 8'd1;
        end else
            wlow_cnt <= 8'd0;
    end

    // Cycles since the read-enable strobe was last low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdoff_cnt <= 8'hFF;
        else if (!ram_rd_en_n)
            rdoff_cnt <= 8'd0;
        else if (rdoff_cnt != 8'hFF)
            rdoff_cnt <= rdoff_cnt + 8'd1;
    end

    // R7
    rd_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dat_oe |-> ram_rd_en_n);

    // R7
    rd_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_en_n |-> ram_rd_en_n);

    // R5
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_en_n |-> (ram_dat_oe && !ram_sel_n && ram_sel));

    // R5
    write_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_en_n) |-> (wlow_cnt >= 8'(N_WR)));

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dat_oe) |-> (rdoff_cnt >= 8'(N_HZ)));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_sel_n && !$past(ram_sel_n)) |->
            ($stable(ram_addr) && $stable(ram_hi_n) && $stable(ram_lo_n)));

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> !req_ready);

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind asram_seq asram_seq_chk #(
    .N_WR(N_WR), .N_HZ(N_HZ), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
    .ram_rd_en_n(ram_rd_en_n), .ram_wr_en_n(ram_wr_en_n),
    .ram_hi_n(ram_hi_n), .ram_lo_n(ram_lo_n), .ram_dat_oe(ram_dat_oe)
);

// File: tb/asram_seq_tb.sv
// Scoreboard bench: driver tasks queue expected read data, a RAM model with
// data-valid delay answers the pins, and a monitor compares responses.
module asram_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [20:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [20:0] ram_addr;
    logic        ram_sel_n, ram_sel, ram_rd_en_n, ram_wr_en_n, ram_hi_n, ram_lo_n;
    logic [15:0] ram_dat_o;
    logic        ram_dat_oe;
    logic [15:0] ram_dat_i = 16'h5A5A;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    asram_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
        .ram_rd_en_n(ram_rd_en_n), .ram_wr_en_n(ram_wr_en_n),
        .ram_hi_n(ram_hi_n), .ram_lo_n(ram_lo_n),
        .ram_dat_o(ram_dat_o), .ram_dat_oe(ram_dat_oe), .ram_dat_i(ram_dat_i)
    );

    logic [15:0] shadow [int];
    logic [15:0] mem    [int];
    logic [15:0] exp_q  [$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        n_cmp++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
        end
    endtask

    function automatic logic [15:0] lanes(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // ---------------- RAM model and pin monitors ----------------
    bit          p_rd, p_wr, p_oe, p_sel;
    int          rd_len, wr_len, drv_len;
    int          rdoff = 1000;
    time         t_act;
    logic [15:0] wr_dat;
    bit          wr_bad, wr_hi, wr_lo;
    logic [20:0] wr_adr, p_addr;
    logic [1:0]  p_lane;
    int          r2_viol = 0, r7_viol = 0, r9_viol = 0;

    always @(negedge clk) begin
        bit          rd, wr, sel;
        logic [15:0] word;
        sel = rst_n && !ram_sel_n && ram_sel;
        rd  = sel && !ram_rd_en_n && ram_wr_en_n;
        wr  = sel && !ram_wr_en_n && (!ram_hi_n || !ram_lo_n);

        // read side: data valid 45 time units after the strobes went active
        if (rd) begin
            if (!p_rd) begin
                t_act  = $time - 2;
                rd_len = 0;
            end
            rd_len++;
            word = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0000;
            ram_dat_i = (($time - t_act) >= 45) ? word : ~word;
        end else begin
            ram_dat_i = 16'h5A5A;
            if (p_rd) check("R3 read strobe cycles", rd_len, 12);
        end

        // R3: the response cycle directly follows the read window
        if (rst_n && rsp_valid) begin
            check("R3 rsp_valid after read window", {p_rd, rd}, 2'b10);
            if (exp_q.size() == 0) begin
                check("R3 unexpected response", 1, 0);
            end else begin
                check("R4 read data", rsp_rdata, exp_q.pop_front());
            end
        end

        // write side: pulse width, data stability and commit
        if (wr) begin
            if (!p_wr) begin
                wr_len = 0;
                wr_dat = ram_dat_o;
                wr_bad = 0;
            end
            wr_len++;
            if (!ram_dat_oe || ram_dat_o !== wr_dat) wr_bad = 1;
            wr_hi  = !ram_hi_n;
            wr_lo  = !ram_lo_n;
            wr_adr = ram_addr;
        end else if (p_wr) begin
            check("R5 write pulse cycles", wr_len, 9);
            check("R5 write data stable and driven", wr_bad, 0);
            word = mem.exists(int'(wr_adr)) ? mem[int'(wr_adr)] : 16'h0000;
            if (wr_hi) word[15:8] = wr_dat[15:8];
            if (wr_lo) word[7:0]  = wr_dat[7:0];
            mem[int'(wr_adr)] = word;
        end

        // R6 drive window length, R8 turnaround
        if (rst_n && ram_dat_oe) begin
            if (!p_oe) check_ge("R8 turnaround cycles", rdoff, 5);
            drv_len++;
        end else if (p_oe) begin
            check("R6 drive window cycles", drv_len, 12);
            drv_len = 0;
        end
        if (!ram_rd_en_n) rdoff = 0;
        else if (rdoff < 1000) rdoff++;

        // continuous rules, reported once at the end
        if (rst_n && !ram_rd_en_n && (ram_dat_oe || !ram_wr_en_n)) r7_viol++;
        if (sel && req_ready) r2_viol++;
        if (sel && p_sel && (ram_addr !== p_addr || {ram_hi_n, ram_lo_n} !== p_lane)) r9_viol++;

        p_rd   = rd;
        p_wr   = wr;
        p_oe   = rst_n && ram_dat_oe;
        p_sel  = sel;
        p_addr = ram_addr;
        p_lane = {ram_hi_n, ram_lo_n};
    end

    // ---------------- driver ----------------
    task automatic issue(input logic w, input logic [20:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_be    = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [20:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] s;
        s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        s = (s & ~lanes(m)) | (d & lanes(m));
        shadow[int'(a)] = s;
        issue(1'b1, a, d, m);
    endtask

    task automatic do_read(input logic [20:0] a, input logic [1:0] m);
        logic [15:0] s;
        s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        exp_q.push_back(s & lanes(m));
        issue(1'b0, a, 16'h0000, m);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        req_be    = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idle pins", {ram_sel_n, ram_sel, ram_rd_en_n, ram_wr_en_n, ram_hi_n,
                               ram_lo_n, ram_dat_oe, req_ready, rsp_valid}, 9'b1_0_1_1_1_1_0_1_0);

        do_write(21'h000010, 16'h1234, 2'b11);
        do_read(21'h000010, 2'b11);
        // R2 busy while the read runs; R4 both lane strobes low
        check("R2 ready low during access", req_ready, 1'b0);
        check("R4 lane strobes for mask 11", {ram_hi_n, ram_lo_n}, 2'b00);

        // read immediately followed by write: turnaround (R8)
        do_write(21'h000020, 16'hBEEF, 2'b01);
        do_read(21'h000020, 2'b11);
        do_write(21'h000020, 16'hCAFE, 2'b10);
        do_read(21'h000020, 2'b10);
        check("R4 lane strobes for mask 10", {ram_hi_n, ram_lo_n}, 2'b01);
        do_read(21'h000020, 2'b01);
        check("R4 lane strobes for mask 01", {ram_hi_n, ram_lo_n}, 2'b10);
        do_read(21'h000020, 2'b00);
        check("R4 lane strobes for mask 00", {ram_hi_n, ram_lo_n}, 2'b11);

        // R10 write with empty mask leaves the word alone
        do_write(21'h000030, 16'h7777, 2'b11);
        do_write(21'h000030, 16'hFFFF, 2'b00);
        check("R10 lane strobes stay high", {ram_hi_n, ram_lo_n}, 2'b11);
        do_read(21'h000030, 2'b11);

        // address extremes
        do_write(21'h1FFFFF, 16'hA55A, 2'b11);
        do_write(21'h000000, 16'h0F0F, 2'b11);
        do_read(21'h1FFFFF, 2'b11);
        do_read(21'h000000, 2'b11);

        // varied patterns, alternating direction
        for (int i = 0; i < 8; i++)
            do_write(21'(32'h100 + i * 37), 16'(32'h1111 * i) ^ 16'h0F0F, 2'(i % 4));
        for (int i = 0; i < 8; i++) begin
            do_read(21'(32'h100 + i * 37), 2'b11);
            do_write(21'(32'h200 + i), 16'(32'hC001 + i * 3), 2'b11);
            do_read(21'(32'h200 + i), 2'(3 - (i % 4)));
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R2 ready low whenever selected", r2_viol, 0);
        check("R7 read enable exclusive", r7_viol, 0);
        check("R9 address and lanes stable", r9_viol, 0);
        done = 1;
        summary();
        $finish;
    end

endmodule